// File: doc/BRIEF.md
# Multiplexed Address/Data Register Interface

This block is a bus slave that sits on a shared 8-bit address/data bus. A host first drives an address and pulses a positive address strobe. The block captures the low seven bus bits when that strobe falls. The same pins then carry data for the rest of the cycle. The latched address selects one byte of a 128-byte space. The bottom fourteen locations (0x00 to 0x0D) are clock and control registers. Locations 0x0E to 0x7F are general-purpose storage.

Access needs an active-low chip select. A read is signalled by the active-low read strobe, and the block drives the bus only while that strobe is low. A write is signalled by the active-low write strobe, and the data is committed when that strobe rises. A synchronous power-fail input overrides chip select, so nothing is read or written while it is high. Some locations and bits cannot be written, and those bits always read as zero. All strobes are asynchronous to the block clock, so each passes through a two-stage synchronizer before its edge is detected.

The data path is split into `ad_i`, `ad_o` and `ad_oe_o`. A pad-level tri-state buffer combines them onto the shared bus.

Top module: `mux_bus_regfile`

## Requirements
- R1: On a falling edge of `as_i`, the latch takes `ad_i[6:0]` as the address. `ad_i[7]` plays no part in selecting a location.
- R2: The address latch updates on every falling strobe, even when `cs_n_i` is high. A later read or write with chip select active uses that latched address.
- R3: A write commits `ad_i` to the latched location on the rising edge of `wr_n_i`. This happens only if `cs_n_i` is low at that moment. A write-strobe pulse with chip select high changes nothing.
- R4: While `pwr_fail_i` is high, no write commits and `ad_oe_o` stays low.
- R5: `ad_oe_o` is high only while `rd_n_i` and `cs_n_i` are both low. Within three clock cycles of `rd_n_i` rising, `ad_oe_o` returns low. While `ad_oe_o` is low, `ad_o` reads zero.
- R6: During a read, `ad_o` shows the byte stored at the latched address.
- R7: Locations 0x0C and 0x0D are read-only. Writes to them are ignored, and they read as 0x00.
- R8: Bit 7 of location 0x00 and bit 7 of location 0x0A are read-only and read as 0. The other bits of these two locations are writable.
- R9: Every location from 0x0E to 0x7F stores and returns all 8 bits. Reset clears neither the storage nor the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset for the synchronizers and the address latch |
| as_i | input | 1 | Address strobe; the address is captured on its falling edge |
| cs_n_i | input | 1 | Active-low chip select |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe; data is committed on its rising edge |
| pwr_fail_i | input | 1 | Synchronous power-fail inhibit; blocks every access while high |
| ad_i | input | 8 | Bus value seen at the pins (address phase, then data phase) |
| ad_o | output | 8 | Read data toward the pins |
| ad_oe_o | output | 1 | Output enable for the bus drivers |

## Verification
A full pass writes a distinct pattern to all 128 locations and reads each one back. This exposes a mis-decoded write mask: a writable bit would be stuck at zero, or a protected location would echo the data written to it. The bench also latches an address without chip select and then reads at that address without a new strobe. A design that gated the latch with chip select would return the wrong byte in that case. Separate cycles check a write pulse with chip select high, accesses during power fail, an address with bit 7 set, and reads after a reset. A design that ignored the gating would corrupt stored data. A design that decoded address bit 7 would write the wrong location. A design that reset its storage would lose its contents on reset.

// File: rtl/mux_bus_regfile.sv
module mux_bus_regfile (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       as_i,
  input  logic       cs_n_i,
  input  logic       rd_n_i,
  input  logic       wr_n_i,
  input  logic       pwr_fail_i,
  input  logic [7:0] ad_i,
  output logic [7:0] ad_o,
  output logic       ad_oe_o
);
  localparam int AW    = 7;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LOC_SEC  = 7'h00;
  localparam logic [AW-1:0] LOC_CTLA = 7'h0A;
  localparam logic [AW-1:0] LOC_STC  = 7'h0C;
  localparam logic [AW-1:0] LOC_STD  = 7'h0D;

  logic [2:0]    as_sy, wr_sy;
  logic [1:0]    rd_sy, cs_sy;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] lane_mask;
  logic          as_fall, wr_rise, cs_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_sy <= 3'b000;
      wr_sy <= 3'b111;
      rd_sy <= 2'b11;
      cs_sy <= 2'b11;
    end else begin
      as_sy <= {as_sy[1:0], as_i};
      wr_sy <= {wr_sy[1:0], wr_n_i};
      rd_sy <= {rd_sy[0], rd_n_i};
      cs_sy <= {cs_sy[0], cs_n_i};
    end
  end

  assign as_fall = as_sy[2] & ~as_sy[1];
  assign wr_rise = ~wr_sy[2] & wr_sy[1];
  assign cs_ok   = ~cs_sy[1] & ~pwr_fail_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (as_fall) addr_q <= ad_i[AW-1:0];
  end

  always_comb begin
    if (addr_q == LOC_STC || addr_q == LOC_STD)       lane_mask = '0;
    else if (addr_q == LOC_SEC || addr_q == LOC_CTLA) lane_mask = {1'b0, {(DW-1){1'b1}}};
    else                                              lane_mask = '1;
  end

  always_ff @(posedge clk) begin
    if (rst_n && wr_rise && cs_ok) mem[addr_q] <= ad_i & lane_mask;
  end

  assign ad_oe_o = cs_ok & ~rd_sy[1];
  assign ad_o    = ad_oe_o ? (mem[addr_q] & lane_mask) : '0;
endmodule

// File: rtl/mux_bus_regfile_chk.sv
module mux_bus_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       as_i,
  input logic       cs_n_i,
  input logic       rd_n_i,
  input logic       pwr_fail_i,
  input logic [7:0] ad_o,
  input logic       ad_oe_o,
  input logic [6:0] addr_q
);
  AST_ADDR_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q != $past(addr_q)) |-> ($past(as_i, 4) && !$past(as_i, 3))); // R1
  AST_OE_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> !$past(rd_n_i, 2)); // R5
  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> !$past(cs_n_i, 2)); // R5
  AST_QUIET_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe_o |-> (ad_o == 8'h00)); // R5
  AST_PFAIL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |-> !ad_oe_o); // R4
  AST_STATUS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe_o && (addr_q == 7'h0C || addr_q == 7'h0D)) |-> (ad_o == 8'h00)); // R7
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe_o && (addr_q == 7'h00 || addr_q == 7'h0A)) |-> !ad_o[7]); // R8
endmodule

bind mux_bus_regfile mux_bus_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .as_i(as_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
  .pwr_fail_i(pwr_fail_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .addr_q(addr_q));

// File: tb/mux_bus_regfile_tb.sv
module mux_bus_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_i = 1'b0, cs_n_i = 1'b1, rd_n_i = 1'b1, wr_n_i = 1'b1, pwr_fail_i = 1'b0;
  logic [7:0] ad_i = 8'h00;
  logic [7:0] ad_o;
  logic ad_oe_o;
  int vectors = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_regfile dut_i (.clk(clk), .rst_n(rst_n), .as_i(as_i), .cs_n_i(cs_n_i),
    .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .pwr_fail_i(pwr_fail_i), .ad_i(ad_i),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o));

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  function automatic logic [7:0] keep(input int a);
    if (a == 12 || a == 13) return 8'h00;
    if (a == 0 || a == 10)  return 8'h7F;
    return 8'hFF;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic latch(input logic [7:0] a, input logic sel_n);
    cs_n_i = sel_n; ad_i = a; as_i = 1'b1; cyc(HOLD);
    as_i = 1'b0; cyc(HOLD);
  endtask

  task automatic strobe_wr(input logic [7:0] d, input logic sel_n);
    cs_n_i = sel_n; ad_i = d; wr_n_i = 1'b0; cyc(HOLD);
    wr_n_i = 1'b1; cyc(HOLD);
    cs_n_i = 1'b1;
  endtask

  task automatic strobe_rd(input string req, input logic exp_oe, input logic [7:0] exp_d);
    cs_n_i = 1'b0; ad_i = 8'h00; rd_n_i = 1'b0; cyc(HOLD);
    check(req, {ad_oe_o, ad_o}, {exp_oe, exp_oe ? exp_d : 8'h00});
    rd_n_i = 1'b1; cyc(3);
    check({req, "_release"}, {ad_oe_o, ad_o}, 9'h000);
    cs_n_i = 1'b1; cyc(2);
  endtask

  initial begin
    cyc(4);
    check("R5_reset", {ad_oe_o, ad_o}, 9'h000);
    rst_n = 1'b1; cyc(3);
    for (int a = 0; a < 128; a++) begin
      latch(8'(a), 1'b0);
      strobe_wr(pat(a), 1'b0);
    end
    for (int a = 0; a < 128; a++) begin
      latch(8'(a), 1'b0);
      strobe_rd((a < 14) ? "R6_R7_R8_sweep" : "R9_sweep", 1'b1, pat(a) & keep(a));
    end
    latch(8'h00, 1'b0); strobe_wr(8'hFF, 1'b0);
    latch(8'h00, 1'b0); strobe_rd("R8_sec", 1'b1, 8'h7F);
    latch(8'h0D, 1'b0); strobe_wr(8'hFF, 1'b0);
    latch(8'h0D, 1'b0); strobe_rd("R7_regd", 1'b1, 8'h00);
    latch(8'h95, 1'b0); strobe_wr(8'hA5, 1'b0);
    latch(8'h15, 1'b0); strobe_rd("R1_bit7_ignored", 1'b1, 8'hA5);
    latch(8'h30, 1'b1);
    strobe_rd("R2_latch_no_cs", 1'b1, pat(8'h30));
    latch(8'h20, 1'b0); strobe_wr(8'h55, 1'b1);
    latch(8'h20, 1'b0); strobe_rd("R3_no_cs_write", 1'b1, pat(8'h20));
    pwr_fail_i = 1'b1;
    latch(8'h21, 1'b0); strobe_wr(8'h66, 1'b0);
    latch(8'h21, 1'b0); strobe_rd("R4_read_blocked", 1'b0, 8'h00);
    pwr_fail_i = 1'b0; cyc(2);
    latch(8'h21, 1'b0); strobe_rd("R4_write_blocked", 1'b1, pat(8'h21));
    latch(8'h40, 1'b0);
    rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(3);
    latch(8'h40, 1'b0); strobe_rd("R9_after_reset", 1'b1, pat(8'h40));
    latch(8'h0B, 1'b0); strobe_rd("R9_reg_after_reset", 1'b1, pat(8'h0B));
    latch(8'h7F, 1'b0); strobe_wr(8'h00, 1'b0);
    latch(8'h7F, 1'b0); strobe_rd("R3_R6_top", 1'b1, 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule